// File: doc/BRIEF.md
# Speculative Write-Back Data Cache

This block is a direct-mapped, one-word-per-line data cache with a write-back policy and support for memory checkpoints. A processor issues loads and stores through a request/response port. Misses and evictions go to a plain word-wide backing memory through a request/acknowledge port. Stores mark lines modified and do not write through. Three command inputs take, commit or roll back a checkpoint.

Each line is invalid, clean, dirty or speculative. While a checkpoint is active, any line that a store writes becomes speculative, so the value from before the checkpoint stays recoverable. Taking a checkpoint is one cycle and does not touch the lines. Commit and rollback start a sweep that visits one line index per clock. Commit turns speculative lines dirty. Rollback invalidates them and discards their data. The block reports busy and stalls the processor port for the whole sweep.

A dirty line from before the checkpoint is written back to memory before it is overwritten speculatively. If a miss has to evict a speculative line, the block first commits the whole checkpoint with a sweep, then writes back the victim as an ordinary dirty line.

Top module: `spec_cache`

## Requirements
- R1: With no checkpoint active, a store marks its line dirty without a memory write. The new value reaches memory only when that line is evicted by a conflicting miss.
- R2: A load miss reads the word from memory and returns it. A later load of the same address returns the cached value without any memory access. Each request gives one `rsp_valid` pulse; for a store, `rsp_rdata` carries the stored value.
- R3: `cmd_ckpt` sampled in idle with no checkpoint active raises `ckpt_active` in the next cycle, with no sweep (`busy` stays low).
- R4: Under an active checkpoint, a store to a clean, invalid or missing line leaves memory untouched. The stored value is visible to later loads.
- R5: Under an active checkpoint, a store hit on a line that was dirty before the checkpoint first writes that line's old value to memory, then takes the new value.
- R6: Commit holds `busy` high for exactly one cycle per line and then gives a one-cycle `done` pulse. `ckpt_active` is low afterwards. Speculative data is kept and becomes dirty, so a later eviction writes it to memory.
- R7: Rollback holds `busy` for one cycle per line, makes no memory write, and clears `ckpt_active`. Later loads return the values from before the checkpoint.
- R8: A miss whose victim is speculative first commits the checkpoint (`ckpt_active` falls), then writes the victim to memory and serves the miss.
- R9: While `busy` is high, `req_ready` is low and no request is accepted.
- R10: Commands are ignored in three cases: commit or rollback with no checkpoint active, any command during a sweep, and `cmd_ckpt` while a checkpoint is already active. When several commands come together, rollback wins over commit.
- R11: After reset, all lines are invalid, no checkpoint is active, `busy` is low and `req_ready` is high.
- R12: A memory request holds `mem_req`, `mem_we` and `mem_addr` steady until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request present |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Store data |
| req_ready | output | 1 | Request accepted this cycle when valid |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Load data, or the stored word for a store |
| mem_req | output | 1 | Memory access pending |
| mem_we | output | 1 | 1 = memory write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory completed the pending access |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ack |
| cmd_ckpt | input | 1 | Take a checkpoint |
| cmd_commit | input | 1 | Commit the active checkpoint |
| cmd_rollback | input | 1 | Roll back the active checkpoint |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle pulse when a commanded sweep ends |
| ckpt_active | output | 1 | A checkpoint is active |

## Verification
The bench builds the cache with ADDR_W=6, DATA_W=16 and IDX_W=2. That gives four lines and a sixteen-word working set, so conflict misses on dirty and speculative lines, save-before-speculate writes and forced commits all happen often. A four-line sweep is short enough that the exact width of each busy window can be counted and compared. A final flush evicts every line so the whole memory can be compared word by word with a reference model.

// File: rtl/sc_pkg.sv
package sc_pkg;
  typedef enum logic [1:0] {
    LN_INV   = 2'd0,
    LN_CLEAN = 2'd1,
    LN_DIRTY = 2'd2,
    LN_SPEC  = 2'd3
  } line_st_e;

  typedef enum logic [2:0] {
    C_IDLE,
    C_LOOK,
    C_EVICT,
    C_FILL,
    C_SAVE,
    C_SWEEP
  } ctl_e;
endpackage

// File: rtl/sc_data_ram.sv
module sc_data_ram #(
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int LINES = 1 << IDX_W;

  logic [DATA_W-1:0] mem_q [LINES];

  // single port, read-first: maps onto a block RAM
  always_ff @(posedge clk) begin
    if (we) mem_q[addr] <= wdata;
    rdata <= mem_q[addr];
  end
endmodule

// File: rtl/sc_meta.sv
module sc_meta
  import sc_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int TAG_W = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic [TAG_W-1:0]     rd_tag,
  output line_st_e             rd_st,
  input  logic [IDX_W-1:0]     sw_idx,
  output logic [TAG_W-1:0]     sw_tag,
  output line_st_e             sw_st,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [TAG_W-1:0]     wr_tag,
  input  line_st_e             wr_st,
  output logic [(1<<IDX_W)-1:0] spec_mask
);
  localparam int LINES = 1 << IDX_W;

  logic [TAG_W-1:0] tag_q [LINES];
  line_st_e         st_q  [LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) st_q[i] <= LN_INV;
    end else if (wr_en) begin
      st_q[wr_idx] <= wr_st;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_idx] <= wr_tag;
  end

  assign rd_tag = tag_q[rd_idx];
  assign rd_st  = st_q[rd_idx];
  assign sw_tag = tag_q[sw_idx];
  assign sw_st  = st_q[sw_idx];

  for (genvar g = 0; g < LINES; g++) begin : g_mask
    assign spec_mask[g] = (st_q[g] == LN_SPEC);
  end
endmodule

// File: rtl/sc_sweep.sv
module sc_sweep #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             rb_in,
  output logic             active,
  output logic             rb_mode,
  output logic [IDX_W-1:0] idx,
  output logic             last
);
  localparam int LINES = 1 << IDX_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINES - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      rb_mode <= 1'b0;
      idx     <= '0;
    end else if (start) begin
      active  <= 1'b1;
      rb_mode <= rb_in;
      idx     <= '0;
    end else if (active) begin
      if (last) active <= 1'b0;
      else      idx    <= idx + 1'b1;
    end
  end

  assign last = active && (idx == LAST_IDX);

  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    start |-> !active);  // R10
  AST_SWEEP_ADVANCES: assert property (@(posedge clk) disable iff (rst)
    (active && !last) |=> active && (idx == $past(idx) + 1'b1));  // R6
endmodule

// File: rtl/spec_cache.sv
module spec_cache
  import sc_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              cmd_ckpt,
  input  logic              cmd_commit,
  input  logic              cmd_rollback,
  output logic              busy,
  output logic              done,
  output logic              ckpt_active
);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int LINES = 1 << IDX_W;

  ctl_e              st_q;
  logic              ckpt_q, forced_q;
  logic              r_we;
  logic [ADDR_W-1:0] r_addr;
  logic [DATA_W-1:0] r_wdata;
  logic [IDX_W-1:0]  r_idx;
  logic [TAG_W-1:0]  r_tag;

  assign r_idx = r_addr[IDX_W-1:0];
  assign r_tag = r_addr[ADDR_W-1:IDX_W];

  // metadata and data storage
  logic [TAG_W-1:0]  rd_tag, sw_tag, mt_tag;
  line_st_e          rd_st, sw_st, mt_st, new_st;
  logic              mt_we, ram_we;
  logic [IDX_W-1:0]  mt_idx, ram_addr, sw_idx;
  logic [DATA_W-1:0] ram_wd, ram_q;
  logic [LINES-1:0]  spec_mask;
  logic              sw_start, sw_rb, sw_active, sw_rb_q, sw_last;

  sc_meta #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_meta (
    .clk(clk), .rst(rst),
    .rd_idx(r_idx), .rd_tag(rd_tag), .rd_st(rd_st),
    .sw_idx(sw_idx), .sw_tag(sw_tag), .sw_st(sw_st),
    .wr_en(mt_we), .wr_idx(mt_idx), .wr_tag(mt_tag), .wr_st(mt_st),
    .spec_mask(spec_mask)
  );

  sc_data_ram #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(ram_wd), .rdata(ram_q)
  );

  sc_sweep #(.IDX_W(IDX_W)) u_sweep (
    .clk(clk), .rst(rst), .start(sw_start), .rb_in(sw_rb),
    .active(sw_active), .rb_mode(sw_rb_q), .idx(sw_idx), .last(sw_last)
  );

  // command decode: rollback beats commit; both need an active checkpoint
  logic idle, do_rb, do_cm, do_ck, accept, hit;
  assign idle   = (st_q == C_IDLE);
  assign do_rb  = cmd_rollback && ckpt_q;
  assign do_cm  = cmd_commit && ckpt_q && !cmd_rollback;
  assign do_ck  = cmd_ckpt && !ckpt_q;
  assign req_ready = idle && !do_rb && !do_cm;
  assign accept = req_valid && req_ready;
  assign hit    = (rd_st != LN_INV) && (rd_tag == r_tag);

  assign ram_addr    = idle ? req_addr[IDX_W-1:0] : r_idx;
  assign busy        = sw_active;
  assign ckpt_active = ckpt_q;

  always_comb begin
    new_st   = ckpt_q ? LN_SPEC : LN_DIRTY;
    ram_we   = 1'b0;
    ram_wd   = r_wdata;
    mt_we    = 1'b0;
    mt_idx   = r_idx;
    mt_tag   = r_tag;
    mt_st    = LN_INV;
    sw_start = 1'b0;
    sw_rb    = 1'b0;
    case (st_q)
      C_IDLE: begin
        if (do_rb || do_cm) begin
          sw_start = 1'b1;
          sw_rb    = do_rb;
        end
      end
      C_LOOK: begin
        if (hit) begin
          if (r_we && !(ckpt_q && rd_st == LN_DIRTY)) begin
            ram_we = 1'b1;
            mt_we  = 1'b1;
            mt_st  = new_st;
          end
        end else if (rd_st == LN_SPEC) begin
          sw_start = 1'b1;  // forced commit before evicting speculative data
        end
      end
      C_FILL: begin
        if (mem_ack) begin
          ram_we = 1'b1;
          ram_wd = r_we ? r_wdata : mem_rdata;
          mt_we  = 1'b1;
          mt_st  = r_we ? new_st : LN_CLEAN;
        end
      end
      C_SAVE: begin
        if (mem_ack) begin
          ram_we = 1'b1;
          mt_we  = 1'b1;
          mt_st  = LN_SPEC;
        end
      end
      C_SWEEP: begin
        if (sw_st == LN_SPEC) begin
          mt_we  = 1'b1;
          mt_idx = sw_idx;
          mt_tag = sw_tag;
          mt_st  = sw_rb_q ? LN_INV : LN_DIRTY;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= C_IDLE;
      ckpt_q    <= 1'b0;
      forced_q  <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      done      <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      r_we      <= 1'b0;
      r_addr    <= '0;
      r_wdata   <= '0;
    end else begin
      rsp_valid <= 1'b0;
      done      <= 1'b0;
      case (st_q)
        C_IDLE: begin
          if (do_ck) ckpt_q <= 1'b1;
          if (sw_start) begin
            st_q <= C_SWEEP;
          end else if (accept) begin
            r_we    <= req_we;
            r_addr  <= req_addr;
            r_wdata <= req_wdata;
            st_q    <= C_LOOK;
          end
        end
        C_LOOK: begin
          if (hit) begin
            if (!r_we) begin
              rsp_valid <= 1'b1;
              rsp_rdata <= ram_q;
              st_q      <= C_IDLE;
            end else if (ckpt_q && rd_st == LN_DIRTY) begin
              mem_req   <= 1'b1;
              mem_we    <= 1'b1;
              mem_addr  <= r_addr;
              mem_wdata <= ram_q;
              st_q      <= C_SAVE;
            end else begin
              rsp_valid <= 1'b1;
              rsp_rdata <= r_wdata;
              st_q      <= C_IDLE;
            end
          end else if (rd_st == LN_SPEC) begin
            forced_q <= 1'b1;
            st_q     <= C_SWEEP;
          end else if (rd_st == LN_DIRTY) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= {rd_tag, r_idx};
            mem_wdata <= ram_q;
            st_q      <= C_EVICT;
          end else begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= r_addr;
            st_q     <= C_FILL;
          end
        end
        C_EVICT: begin
          if (mem_ack) begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= r_addr;
            st_q     <= C_FILL;
          end
        end
        C_FILL, C_SAVE: begin
          if (mem_ack) begin
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            rsp_valid <= 1'b1;
            rsp_rdata <= (st_q == C_FILL && !r_we) ? mem_rdata : r_wdata;
            st_q      <= C_IDLE;
          end
        end
        C_SWEEP: begin
          if (sw_last) begin
            ckpt_q   <= 1'b0;
            forced_q <= 1'b0;
            if (forced_q) begin
              st_q <= C_LOOK;
            end else begin
              st_q <= C_IDLE;
              done <= 1'b1;
            end
          end
        end
        default: st_q <= C_IDLE;
      endcase
    end
  end

  AST_CKPT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (idle && cmd_ckpt && !ckpt_active && !cmd_commit && !cmd_rollback)
      |=> ckpt_active && !busy);  // R3
  AST_SWEEP_STALLS: assert property (@(posedge clk) disable iff (rst)
    busy |-> !req_ready);  // R9
  AST_SWEEP_NO_MEM: assert property (@(posedge clk) disable iff (rst)
    busy |-> !mem_req);  // R7
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_we));  // R12
  AST_NO_SPEC_WITHOUT_CKPT: assert property (@(posedge clk) disable iff (rst)
    !ckpt_active |-> (spec_mask == '0));  // R6
  AST_DONE_ENDS_SWEEP: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && $past(busy));  // R6
  AST_SWEEP_MATCHES_CTL: assert property (@(posedge clk) disable iff (rst)
    sw_active == (st_q == C_SWEEP));  // R9
endmodule

// File: tb/spec_cache_tb.sv
module spec_cache_tb;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int IW = 2;
  localparam int LINES = 1 << IW;
  localparam int WORDS = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          req_valid = 0, req_we = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_ack = 0;
  logic [DW-1:0] mem_rdata = '0;
  logic          cmd_ckpt = 0, cmd_commit = 0, cmd_rollback = 0;
  logic          busy, done, ckpt_active;

  spec_cache #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW)) u_dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .cmd_ckpt(cmd_ckpt), .cmd_commit(cmd_commit), .cmd_rollback(cmd_rollback),
    .busy(busy), .done(done), .ckpt_active(ckpt_active)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] init_val(input int a);
    return DW'(16'h4000 ^ (a * 37));
  endfunction

  // backing memory with two-cycle latency; checks the request stays put
  logic [DW-1:0] bmem [WORDS];
  int            rd_cnt = 0, wr_cnt = 0;
  bit            pend = 0;
  logic [AW-1:0] pend_addr;
  logic          pend_we;

  initial for (int i = 0; i < WORDS; i++) bmem[i] = init_val(i);

  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req && !pend) begin
      pend = 1;
      pend_addr = mem_addr;
      pend_we = mem_we;
    end else if (mem_req && pend) begin
      pend = 0;
      chk(mem_addr == pend_addr && mem_we == pend_we, "R12 request held", int'(mem_addr), int'(pend_addr));
      if (mem_we) begin
        bmem[mem_addr] = mem_wdata;
        wr_cnt++;
      end else begin
        mem_rdata = bmem[mem_addr];
        rd_cnt++;
      end
      mem_ack = 1'b1;
    end
  end

  // reference model of the processor-visible memory
  logic [DW-1:0] arch [WORDS];
  logic [DW-1:0] snap [WORDS];
  bit            m_ckpt = 0;
  initial for (int i = 0; i < WORDS; i++) arch[i] = init_val(i);

  task automatic do_req(input bit we, input int a, input logic [DW-1:0] d, output logic [DW-1:0] q);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_we = we; req_addr = AW'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    while (!rsp_valid) @(negedge clk);
    q = rsp_rdata;
    if (we) arch[a] = d;
    if (m_ckpt && !ckpt_active) m_ckpt = 0;  // a forced commit happened
  endtask

  task automatic store(input int a, input logic [DW-1:0] d);
    logic [DW-1:0] q;
    do_req(1, a, d, q);
  endtask

  task automatic load_chk(input int a, input string tag);
    logic [DW-1:0] q;
    do_req(0, a, '0, q);
    chk(q == arch[a], tag, int'(q), int'(arch[a]));
  endtask

  // kind: 0 checkpoint, 1 commit, 2 rollback
  task automatic run_cmd(input int kind, output int bcyc, output bit saw_done, output int ready_bad);
    @(negedge clk);
    cmd_ckpt = (kind == 0); cmd_commit = (kind == 1); cmd_rollback = (kind == 2);
    @(negedge clk);
    cmd_ckpt = 0; cmd_commit = 0; cmd_rollback = 0;
    bcyc = 0; saw_done = done; ready_bad = 0;
    while (busy) begin
      bcyc++;
      if (req_ready) ready_bad++;
      @(negedge clk);
      if (done) saw_done = 1;
    end
    if (kind == 0 && !m_ckpt) begin
      m_ckpt = 1;
      for (int i = 0; i < WORDS; i++) snap[i] = arch[i];
    end else if (kind == 1 && m_ckpt) begin
      m_ckpt = 0;
    end else if (kind == 2 && m_ckpt) begin
      m_ckpt = 0;
      for (int i = 0; i < WORDS; i++) arch[i] = snap[i];
    end
  endtask

  task automatic t_reset_and_writeback;
    int r0, w0;
    chk(req_ready == 1, "R11 req_ready after reset", req_ready, 1);
    chk(busy == 0 && ckpt_active == 0, "R11 idle after reset", {busy, ckpt_active}, 0);
    chk(mem_req == 0, "R11 no memory request", mem_req, 0);
    r0 = rd_cnt;
    load_chk(1, "R2 load miss value");
    chk(rd_cnt == r0 + 1, "R11 R2 first access misses", rd_cnt - r0, 1);
    load_chk(1, "R2 load hit value");
    chk(rd_cnt == r0 + 1, "R2 hit makes no read", rd_cnt - r0, 1);
    w0 = wr_cnt;
    store(1, 16'hAAAA);
    chk(wr_cnt == w0 && bmem[1] == init_val(1), "R1 store stays in cache", int'(bmem[1]), int'(init_val(1)));
    load_chk(1, "R1 store visible");
    load_chk(5, "R2 conflict load");
    chk(bmem[1] == 16'hAAAA, "R1 eviction writes back", int'(bmem[1]), 16'hAAAA);
  endtask

  task automatic t_ckpt_commit;
    int bc, rb, w0; bit sd;
    store(10, 16'hB0B0);
    @(negedge clk); cmd_ckpt = 1;
    @(negedge clk); cmd_ckpt = 0;
    m_ckpt = 1; for (int i = 0; i < WORDS; i++) snap[i] = arch[i];
    chk(ckpt_active == 1, "R3 checkpoint active next cycle", ckpt_active, 1);
    chk(busy == 0, "R3 no sweep on checkpoint", busy, 0);
    w0 = wr_cnt;
    store(10, 16'hB1B1);
    chk(bmem[10] == 16'hB0B0 && wr_cnt == w0 + 1, "R5 old dirty value saved", int'(bmem[10]), 16'hB0B0);
    w0 = wr_cnt;
    store(3, 16'hC3C3);
    chk(bmem[3] == init_val(3) && wr_cnt == w0, "R4 speculative store leaves memory", int'(bmem[3]), int'(init_val(3)));
    load_chk(3, "R4 speculative value visible");
    run_cmd(1, bc, sd, rb);
    chk(bc == LINES, "R6 commit busy length", bc, LINES);
    chk(sd == 1, "R6 done pulse", sd, 1);
    chk(rb == 0, "R9 stalled during commit", rb, 0);
    chk(ckpt_active == 0, "R6 checkpoint cleared", ckpt_active, 0);
    load_chk(10, "R6 committed value kept");
    load_chk(3, "R6 committed value kept");
    load_chk(7, "R6 conflict load");
    chk(bmem[3] == 16'hC3C3, "R6 committed line is dirty", int'(bmem[3]), 16'hC3C3);
  endtask

  task automatic t_rollback;
    int bc, rb, w0; bit sd;
    run_cmd(0, bc, sd, rb);
    store(10, 16'hD0D0);
    store(1, 16'hD1D1);
    w0 = wr_cnt;
    run_cmd(2, bc, sd, rb);
    chk(bc == LINES, "R7 rollback busy length", bc, LINES);
    chk(rb == 0, "R9 stalled during rollback", rb, 0);
    chk(wr_cnt == w0, "R7 rollback writes nothing", wr_cnt - w0, 0);
    chk(ckpt_active == 0, "R7 checkpoint cleared", ckpt_active, 0);
    load_chk(10, "R7 value restored");
    load_chk(1, "R7 value restored");
  endtask

  task automatic t_forced_commit;
    int bc, rb; bit sd;
    run_cmd(0, bc, sd, rb);
    store(0, 16'hE0E0);
    load_chk(4, "R8 miss over speculative line");
    chk(ckpt_active == 0, "R8 checkpoint committed", ckpt_active, 0);
    chk(bmem[0] == 16'hE0E0, "R8 victim written back", int'(bmem[0]), 16'hE0E0);
    run_cmd(2, bc, sd, rb);
    chk(bc == 0 && sd == 0, "R10 rollback without checkpoint ignored", bc, 0);
    load_chk(0, "R10 data intact after ignored rollback");
  endtask

  task automatic t_ignored;
    int bc, rb; bit sd;
    run_cmd(1, bc, sd, rb);
    chk(bc == 0 && sd == 0, "R10 commit without checkpoint ignored", bc, 0);
    run_cmd(0, bc, sd, rb);
    store(2, 16'hF2F2);
    run_cmd(0, bc, sd, rb);  // second checkpoint must not move the restore point
    chk(bc == 0 && ckpt_active == 1, "R10 repeated checkpoint", bc, 0);
    store(9, 16'hF9F9);
    run_cmd(2, bc, sd, rb);
    load_chk(2, "R10 rollback reaches first checkpoint");
    load_chk(9, "R10 rollback reaches first checkpoint");
    // commands during a sweep
    run_cmd(0, bc, sd, rb);
    store(2, 16'h1234);
    @(negedge clk); cmd_commit = 1;
    @(negedge clk); cmd_commit = 0; cmd_rollback = 1; cmd_ckpt = 1;
    @(negedge clk); cmd_rollback = 0; cmd_ckpt = 0;
    while (busy) @(negedge clk);
    m_ckpt = 0;
    chk(ckpt_active == 0, "R10 commands during sweep ignored", ckpt_active, 0);
    load_chk(2, "R10 commit not turned into rollback");
    // rollback wins over commit
    run_cmd(0, bc, sd, rb);
    store(2, 16'h5678);
    @(negedge clk); cmd_commit = 1; cmd_rollback = 1;
    @(negedge clk); cmd_commit = 0; cmd_rollback = 0;
    while (busy) @(negedge clk);
    m_ckpt = 0; arch[2] = 16'h1234;
    load_chk(2, "R10 rollback has priority");
  endtask

  task automatic t_random;
    int bc, rb; bit sd;
    for (int n = 0; n < 400; n++) begin
      int r, a;
      r = $urandom_range(99);
      a = $urandom_range(15);
      if (r < 6)       run_cmd(0, bc, sd, rb);
      else if (r < 10) begin run_cmd(1, bc, sd, rb); chk(rb == 0, "R9 random stall", rb, 0); end
      else if (r < 14) begin run_cmd(2, bc, sd, rb); chk(rb == 0, "R9 random stall", rb, 0); end
      else if (r < 55) store(a, DW'($urandom));
      else             load_chk(a, "R7 random load vs model");
    end
    if (m_ckpt) run_cmd(1, bc, sd, rb);
    for (int a = 0; a < 16; a++) load_chk(a, "R6 final load vs model");
    for (int a = 16; a < 16 + LINES; a++) load_chk(a, "R1 flush load");
    for (int a = 0; a < 16; a++)
      chk(bmem[a] == arch[a], "R1 memory after flush", int'(bmem[a]), int'(arch[a]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset_and_writeback();
    t_ckpt_commit();
    t_rollback();
    t_forced_commit();
    t_ignored();
    t_random();
    repeat (4) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule